// File: doc/BRIEF.md
# SD Data Line Error Checker

This block sits beside the DAT-line engine of an SD host controller and decides when a data transfer has gone wrong. It does not deserialise bits or compute CRC16 itself. The surrounding logic hands it finished results: the three-bit status token a card returns after a written block, with the stop bit that follows it; a pass/fail flag and the final stop bit for each received read block; the level of the busy signal on DAT0; and a strobe at the start of each wait. The block turns these into three error pulses (timeout, CRC and end bit), each ready to be OR-ed into a sticky interrupt status register.

A single wait counter serves four kinds of wait. Two are busy waits: one after a response that carries busy, and one after the write status token. The other two wait for an event: the write status token after a written block, and the first read data block after a read command. A start strobe names the kind of wait and clears the counter. The counter then moves forward only on SDCLK-rate enable ticks. If the programmed limit is reached before the awaited event arrives, the block raises a single timeout pulse and the counter stops.

Top module: `sd_dat_err_chk`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, all three error outputs are 0 and no wait is in progress.
- R2: A `wst_valid` strobe with `wst_token` different from 3'b010 raises `err_crc` on the next cycle. A token equal to 3'b010 does not raise it.
- R3: A `rd_done` strobe with `rd_crc_ok` low raises `err_crc` on the next cycle.
- R4: A `wst_valid` strobe with `wst_stop` low, or a `rd_done` strobe with `rd_stop` low, raises `err_endbit` on the next cycle.
- R5: `wait_go` starts a wait of the kind in `wait_kind` and restarts the counter from zero. This happens even if a wait is already running. Kind codes: 0 is busy after a response, 1 is busy after the write status token, 2 is waiting for the write status token, 3 is waiting for read data.
- R6: The wait counter moves forward only on cycles where `sdclk_en` is high.
- R7: If the awaited event has not arrived, `err_tmo` pulses for one cycle right after the tick that brings the count to `tmo_limit`. The wait then ends and does not raise a second pulse.
- R8: An awaited event that arrives on the tick that would bring the count to `tmo_limit` counts as in time and raises no timeout.
- R9: A busy wait (kind 0 or 1) ends on a tick where `busy` is low. A kind 2 wait ends on `wst_valid`. A kind 3 wait ends on `rd_start`.
- R10: When `tmo_limit` is 0, no timeout is ever raised.
- R11: Each error output is high for only one cycle per triggering event. It is registered, so it appears one clock after the inputs that cause it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sdclk_en | input | 1 | One-cycle tick at the SD bus clock rate |
| tmo_limit | input | CNT_W | Timeout limit in ticks (0 disables the timeout) |
| wait_go | input | 1 | Starts a wait of the kind in `wait_kind` |
| wait_kind | input | 2 | Kind of wait to start (see R5) |
| busy | input | 1 | High while the card holds DAT0 busy |
| wst_valid | input | 1 | Write status token received this cycle |
| wst_token | input | 3 | Value of the write status token |
| wst_stop | input | 1 | Stop bit sampled after the status token |
| rd_start | input | 1 | Start of read data seen on the DAT lines |
| rd_done | input | 1 | Read block finished this cycle |
| rd_crc_ok | input | 1 | CRC of the finished read block matched |
| rd_stop | input | 1 | Stop bit sampled at the end of the read block |
| err_tmo | output | 1 | Data timeout pulse |
| err_crc | output | 1 | Data CRC error pulse |
| err_endbit | output | 1 | Data end bit error pulse |

## Verification
The checker tests the token rules on every cycle: each bad status token, each failed read CRC and each low stop bit must produce its pulse one cycle later, and clean inputs must not. It also checks that the timeout pulse never lasts two cycles, never follows a cycle without a tick or with a zero limit, and never follows a restart. Some behaviour depends on how many ticks were counted since the last start. This covers the exact tick on which a timeout fires, an event arriving on that tick, a restart part-way through a wait, and a busy release that ends the wait. Only the bench's reference model and its scenarios can show these.

// File: rtl/sd_dat_err_pkg.sv
package sd_dat_err_pkg;

    // Status token value that means the card accepted the written block
    localparam logic [2:0] WST_ACCEPT = 3'b010;

    typedef enum logic [1:0] {
        WK_BUSY_RESP = 2'd0,
        WK_BUSY_WST  = 2'd1,
        WK_WST_TOKEN = 2'd2,
        WK_RD_DATA   = 2'd3
    } wait_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE      = 3'd0,
        PH_BUSY_RESP = 3'd1,
        PH_BUSY_WST  = 3'd2,
        PH_WST_TOKEN = 3'd3,
        PH_RD_DATA   = 3'd4
    } wait_phase_e;

    typedef struct packed {
        logic tmo;
        logic crc;
        logic endbit;
    } dat_err_t;

    function automatic wait_phase_e phase_of(input wait_kind_e k);
        case (k)
            WK_BUSY_RESP: return PH_BUSY_RESP;
            WK_BUSY_WST:  return PH_BUSY_WST;
            WK_WST_TOKEN: return PH_WST_TOKEN;
            default:      return PH_RD_DATA;
        endcase
    endfunction

    function automatic logic is_busy_phase(input wait_phase_e p);
        return (p == PH_BUSY_RESP) || (p == PH_BUSY_WST);
    endfunction

endpackage

// File: rtl/sd_dat_wait_timer.sv
module sd_dat_wait_timer
    import sd_dat_err_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    input  logic             go,
    input  wait_kind_e       kind,
    input  logic             busy,
    input  logic             wst_valid,
    input  logic             rd_start,
    output logic             tmo_pulse
);

    wait_phase_e      phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;
    logic             ev_done;
    logic             limit_hit;

    // Decide whether the awaited event for the current phase is present
    always_comb begin
        unique case (phase_q)
            PH_BUSY_RESP, PH_BUSY_WST: ev_done = tick && !busy;
            PH_WST_TOKEN:              ev_done = wst_valid;
            PH_RD_DATA:                ev_done = rd_start;
            default:                   ev_done = 1'b0;
        endcase
    end

    assign cnt_inc   = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign limit_hit = (limit != '0) && (cnt_inc >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            cnt_q     <= '0;
            tmo_pulse <= 1'b0;
        end else begin
            tmo_pulse <= 1'b0;
            if (go) begin
                phase_q <= phase_of(kind);
                cnt_q   <= '0;
            end else if (phase_q != PH_IDLE) begin
                if (ev_done) begin
                    phase_q <= PH_IDLE;
                end else if (tick) begin
                    if (limit_hit) begin
                        tmo_pulse <= 1'b1;
                        phase_q   <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_inc[CNT_W-1:0];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/sd_dat_token_chk.sv
module sd_dat_token_chk
    import sd_dat_err_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wst_valid,
    input  logic [2:0] wst_token,
    input  logic       wst_stop,
    input  logic       rd_done,
    input  logic       rd_crc_ok,
    input  logic       rd_stop,
    output logic       crc_pulse,
    output logic       endbit_pulse
);

    logic [1:0] crc_src;
    logic [1:0] stop_src;

    // Lane 0: write status token, lane 1: read data block
    always_comb begin
        crc_src[0]  = wst_valid && (wst_token != WST_ACCEPT);
        stop_src[0] = wst_valid && !wst_stop;
        crc_src[1]  = rd_done && !rd_crc_ok;
        stop_src[1] = rd_done && !rd_stop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_pulse    <= 1'b0;
            endbit_pulse <= 1'b0;
        end else begin
            crc_pulse    <= |crc_src;
            endbit_pulse <= |stop_src;
        end
    end

endmodule

// File: rtl/sd_dat_err_chk.sv
module sd_dat_err_chk
    import sd_dat_err_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sdclk_en,
    input  logic [CNT_W-1:0] tmo_limit,
    input  logic             wait_go,
    input  logic [1:0]       wait_kind,
    input  logic             busy,
    input  logic             wst_valid,
    input  logic [2:0]       wst_token,
    input  logic             wst_stop,
    input  logic             rd_start,
    input  logic             rd_done,
    input  logic             rd_crc_ok,
    input  logic             rd_stop,
    output logic             err_tmo,
    output logic             err_crc,
    output logic             err_endbit
);

    dat_err_t errs;

    sd_dat_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .tick      (sdclk_en),
        .limit     (tmo_limit),
        .go        (wait_go),
        .kind      (wait_kind_e'(wait_kind)),
        .busy      (busy),
        .wst_valid (wst_valid),
        .rd_start  (rd_start),
        .tmo_pulse (errs.tmo)
    );

    sd_dat_token_chk u_tokens (
        .clk          (clk),
        .rst          (rst),
        .wst_valid    (wst_valid),
        .wst_token    (wst_token),
        .wst_stop     (wst_stop),
        .rd_done      (rd_done),
        .rd_crc_ok    (rd_crc_ok),
        .rd_stop      (rd_stop),
        .crc_pulse    (errs.crc),
        .endbit_pulse (errs.endbit)
    );

    assign err_tmo    = errs.tmo;
    assign err_crc    = errs.crc;
    assign err_endbit = errs.endbit;

endmodule

// File: rtl/sd_dat_err_chk_sva.sv
module sd_dat_err_chk_sva #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             sdclk_en,
    input logic [CNT_W-1:0] tmo_limit,
    input logic             wait_go,
    input logic             wst_valid,
    input logic [2:0]       wst_token,
    input logic             wst_stop,
    input logic             rd_done,
    input logic             rd_crc_ok,
    input logic             rd_stop,
    input logic             err_tmo,
    input logic             err_crc,
    input logic             err_endbit
);

    logic bad_crc_in;
    logic bad_stop_in;
    assign bad_crc_in  = (wst_valid && wst_token != 3'b010) || (rd_done && !rd_crc_ok);
    assign bad_stop_in = (wst_valid && !wst_stop) || (rd_done && !rd_stop);

    p_bad_token_r2: assert property (@(posedge clk) disable iff (rst)
        (wst_valid && wst_token != 3'b010) |=> err_crc);

    p_read_crc_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_done && !rd_crc_ok) |=> err_crc);

    p_clean_crc_r2: assert property (@(posedge clk) disable iff (rst)
        !bad_crc_in |=> !err_crc);

    p_stop_bit_r4: assert property (@(posedge clk) disable iff (rst)
        bad_stop_in |=> err_endbit);

    p_clean_stop_r4: assert property (@(posedge clk) disable iff (rst)
        !bad_stop_in |=> !err_endbit);

    p_tmo_single_r11: assert property (@(posedge clk) disable iff (rst)
        err_tmo |=> !err_tmo);

    p_tmo_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
        !sdclk_en |=> !err_tmo);

    p_limit_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (tmo_limit == '0) |=> !err_tmo);

    p_restart_r5: assert property (@(posedge clk) disable iff (rst)
        wait_go |=> !err_tmo);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!err_tmo && !err_crc && !err_endbit));

endmodule

bind sd_dat_err_chk sd_dat_err_chk_sva #(.CNT_W(CNT_W)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .sdclk_en   (sdclk_en),
    .tmo_limit  (tmo_limit),
    .wait_go    (wait_go),
    .wst_valid  (wst_valid),
    .wst_token  (wst_token),
    .wst_stop   (wst_stop),
    .rd_done    (rd_done),
    .rd_crc_ok  (rd_crc_ok),
    .rd_stop    (rd_stop),
    .err_tmo    (err_tmo),
    .err_crc    (err_crc),
    .err_endbit (err_endbit)
);

// File: tb/sd_dat_err_chk_tb_top.sv
module sd_dat_err_chk_tb_top;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sdclk_en = 1'b0;
    logic [CNT_W-1:0] tmo_limit = '0;
    logic             wait_go = 1'b0;
    logic [1:0]       wait_kind = 2'd0;
    logic             busy = 1'b0;
    logic             wst_valid = 1'b0;
    logic [2:0]       wst_token = 3'b010;
    logic             wst_stop = 1'b1;
    logic             rd_start = 1'b0;
    logic             rd_done = 1'b0;
    logic             rd_crc_ok = 1'b1;
    logic             rd_stop = 1'b1;
    logic             err_tmo, err_crc, err_endbit;

    int total = 0;
    int bad = 0;
    int tmo_seen = 0;

    // reference model state
    bit m_active = 0;
    int m_kind = 0;
    int m_cnt = 0;
    bit x_tmo = 0, x_crc = 0, x_eb = 0;

    always #5 clk = ~clk;

    sd_dat_err_chk #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .sdclk_en(sdclk_en), .tmo_limit(tmo_limit),
        .wait_go(wait_go), .wait_kind(wait_kind), .busy(busy),
        .wst_valid(wst_valid), .wst_token(wst_token), .wst_stop(wst_stop),
        .rd_start(rd_start), .rd_done(rd_done), .rd_crc_ok(rd_crc_ok),
        .rd_stop(rd_stop), .err_tmo(err_tmo), .err_crc(err_crc),
        .err_endbit(err_endbit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Model step taken at each rising edge from the inputs held there
    task automatic model_step();
        bit ev;
        if (rst) begin
            m_active = 0; m_cnt = 0;
            x_tmo = 0; x_crc = 0; x_eb = 0;
            return;
        end
        x_crc = (wst_valid && wst_token != 3'b010) || (rd_done && !rd_crc_ok);
        x_eb  = (wst_valid && !wst_stop) || (rd_done && !rd_stop);
        x_tmo = 0;
        if (wait_go) begin
            m_active = 1; m_kind = int'(wait_kind); m_cnt = 0;
        end else if (m_active) begin
            if (m_kind < 2)       ev = sdclk_en && !busy;
            else if (m_kind == 2) ev = wst_valid;
            else                  ev = rd_start;
            if (ev) m_active = 0;
            else if (sdclk_en) begin
                m_cnt++;
                if (tmo_limit != 0 && m_cnt >= int'(tmo_limit)) begin
                    x_tmo = 1; m_active = 0;
                end
            end
        end
    endtask

    // One clock: model at the rising edge, compare at the falling edge
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(err_tmo == x_tmo, "R7 err_tmo", err_tmo, x_tmo);
        check(err_crc == x_crc, "R2 R3 err_crc", err_crc, x_crc);
        check(err_endbit == x_eb, "R4 err_endbit", err_endbit, x_eb);
        if (err_tmo) tmo_seen++;
    endtask

    // n ticks, each preceded by gap-1 idle cycles
    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            sdclk_en = 1'b0;
            for (int j = 1; j < gap; j++) cyc();
            sdclk_en = 1'b1;
            cyc();
        end
        sdclk_en = 1'b0;
    endtask

    task automatic start_wait(input int kind);
        wait_go = 1'b1; wait_kind = kind[1:0];
        cyc();
        wait_go = 1'b0;
        tmo_seen = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        @(negedge clk);
        cyc(); cyc();
        check(!err_tmo && !err_crc && !err_endbit, "R1 outputs in reset", {err_tmo, err_crc, err_endbit}, 0);
        rst = 1'b0;
        cyc();
        check(!err_tmo && !err_crc && !err_endbit, "R1 after reset", {err_tmo, err_crc, err_endbit}, 0);
        tmo_seen = 0;
        ticks(20, 1);
        check(tmo_seen == 0, "R1 no wait active", tmo_seen, 0);

        // R2 every status token value
        for (int v = 0; v < 8; v++) begin
            wst_valid = 1'b1; wst_token = v[2:0];
            cyc();
            check(err_crc == (v != 2), "R2 token value", err_crc, v != 2);
            wst_valid = 1'b0; wst_token = 3'b010;
            cyc();
            check(err_crc == 0, "R11 crc pulse width", err_crc, 0);
        end

        // R3 read CRC mismatch
        rd_done = 1'b1; rd_crc_ok = 1'b0;
        cyc();
        check(err_crc == 1, "R3 read crc bad", err_crc, 1);
        rd_crc_ok = 1'b1;
        cyc();
        check(err_crc == 0, "R3 read crc good", err_crc, 0);
        rd_done = 1'b0;

        // R4 stop bits
        wst_valid = 1'b1; wst_stop = 1'b0;
        cyc();
        check(err_endbit == 1 && err_crc == 0, "R4 token stop bit", err_endbit, 1);
        wst_valid = 1'b0; wst_stop = 1'b1;
        rd_done = 1'b1; rd_stop = 1'b0;
        cyc();
        check(err_endbit == 1, "R4 read stop bit", err_endbit, 1);
        rd_done = 1'b0; rd_stop = 1'b1;
        cyc();
        check(err_endbit == 0, "R11 endbit pulse width", err_endbit, 0);

        // R5 R7 each kind times out exactly once, sparse ticks
        tmo_limit = 16'd4;
        busy = 1'b1;
        for (int k = 0; k < 4; k++) begin
            start_wait(k);
            ticks(12, 3);
            check(tmo_seen == 1, "R7 single timeout per kind", tmo_seen, 1);
        end

        // R8 event on the limit tick is in time
        start_wait(2);
        ticks(3, 1);
        wst_valid = 1'b1; sdclk_en = 1'b1;
        cyc();
        wst_valid = 1'b0; sdclk_en = 1'b0;
        ticks(10, 1);
        check(tmo_seen == 0, "R8 token on limit tick", tmo_seen, 0);
        start_wait(3);
        ticks(4, 1);
        check(tmo_seen == 1, "R8 limit tick without event", tmo_seen, 1);

        // R6 no ticks, no progress
        tmo_limit = 16'd5;
        start_wait(3);
        for (int i = 0; i < 100; i++) cyc();
        check(tmo_seen == 0, "R6 no count without tick", tmo_seen, 0);
        ticks(4, 2);
        check(tmo_seen == 0, "R6 four ticks of five", tmo_seen, 0);
        ticks(1, 2);
        check(tmo_seen == 1, "R6 fifth tick", tmo_seen, 1);

        // R5 restart mid-wait
        start_wait(0);
        ticks(4, 1);
        start_wait(0);
        ticks(4, 1);
        check(tmo_seen == 0, "R5 restart clears count", tmo_seen, 0);
        ticks(1, 1);
        check(tmo_seen == 1, "R5 timeout after restart", tmo_seen, 1);

        // R9 busy release ends the wait only on a tick
        start_wait(1);
        ticks(2, 1);
        busy = 1'b0;
        cyc(); cyc();
        busy = 1'b1;
        ticks(2, 1);
        check(tmo_seen == 0, "R9 release without tick", tmo_seen, 0);
        busy = 1'b0;
        ticks(1, 1);
        busy = 1'b1;
        ticks(20, 1);
        check(tmo_seen == 0, "R9 busy release ends wait", tmo_seen, 0);
        start_wait(3);
        rd_start = 1'b1;
        cyc();
        rd_start = 1'b0;
        ticks(20, 1);
        check(tmo_seen == 0, "R9 read start ends wait", tmo_seen, 0);

        // R10 zero limit disables the timeout
        tmo_limit = '0;
        start_wait(0);
        ticks(300, 1);
        check(tmo_seen == 0, "R10 zero limit", tmo_seen, 0);
        busy = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule